// File: doc/BRIEF.md
# Cartridge Program Bank Mapper

This block sits between an 8-bit console CPU and a cartridge program ROM that is larger than the CPU can see at once. It watches CPU writes anywhere from 6000h to FFFFh and decodes a few of them as register loads. Those registers select which 8 KB ROM pages appear in the CPU's program windows. The same write decoder also holds a 2-bit nametable mirroring selector that the video side of the cartridge uses.

Four 8 KB windows cover 8000h-FFFFh. Three of them come from bank registers loaded from the data bus, and the top one is fixed to the last ROM page. An extra 8 KB window at 6000h-7FFFh also reads ROM. Its page register is loaded from the low six bits of the write address, and the data byte plays no part in that load. Every bank number is reduced to the ROM's size before use, so an oversized number wraps around instead of addressing beyond the part. The ROM address output is combinational from the CPU address. The ROM size is set by a parameter that must be a power of two.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset, all four bank registers hold 0 and the mirroring output is 0 (vertical). A read at 8000h-DFFFh or 6000h-7FFFh then yields ROM address equal to CPU address bits 12:0.
- R2: A write whose address ANDed with F80Ch equals 8800h, A800h or A000h loads bank register 0, 1 or 2 respectively from the full 8-bit data byte. Address bits outside the mask have no effect, so 8BF3h also loads register 0.
- R3: A write whose address ANDed with F800h equals 6800h loads the low-window register from address bits 5:0. The data byte is ignored for this write, and this decode is checked before all others.
- R4: A write whose address ANDed with F80Ch equals 9800h loads the mirroring output from data bits 1:0. The codes are 0 = vertical, 1 = horizontal, 2 = single-screen A and 3 = single-screen B.
- R5: Reads map by CPU address bits 15:13. The value 3 (6000h-7FFFh) uses the low-window register, 4 uses register 0, 5 uses register 1 and 6 uses register 2. The ROM address is (bank AND (BANKS-1)) × 8192 + CPU address bits 12:0.
- R6: Reads at E000h-FFFFh always use bank BANKS-1, whatever the registers hold.
- R7: Bank numbers at or above BANKS wrap by the mask. For example, with 16 banks, value 0x35 selects bank 5.
- R8: Writes to any other masked address in 6000h-FFFFh change no register and not the mirroring output. This includes 8804h, 9000h, B000h, C000h, F000h, 6000h and 7000h. Cycles with the write strobe low also change nothing.
- R9: Below 6000h, writes change nothing and the ROM address output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe; a write is taken at the rising clock edge while high |
| rom_addr | output | $clog2(BANKS)+13 | Program ROM byte address for the current CPU address |
| mirror_mode | output | 2 | Nametable mirroring selector |

## Verification
The assertions assume that the CPU address and write strobe are settled at each rising edge. They also assume the write strobe is a one-cycle pulse per CPU write, so that a held strobe is not mistaken for repeated loads. The bench changes inputs only on falling edges and pulses the strobe for exactly one cycle per write. It also drives addresses and data outside every decoded pattern, including addresses in the 6800h window whose data byte differs from the address bits. This shows that only the intended register moves.

// File: rtl/prg_bank_mapper_pkg.sv
package prg_bank_mapper_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int LOWB_W = 6;
  localparam int PAGE_W = 13;

  localparam logic [ADDR_W-1:0] REG_MASK   = 16'hF80C;
  localparam logic [ADDR_W-1:0] LOWW_MASK  = 16'hF800;
  localparam logic [ADDR_W-1:0] LOWW_MATCH = 16'h6800;
  localparam logic [ADDR_W-1:0] B0_MATCH   = 16'h8800;
  localparam logic [ADDR_W-1:0] B1_MATCH   = 16'hA800;
  localparam logic [ADDR_W-1:0] B2_MATCH   = 16'hA000;
  localparam logic [ADDR_W-1:0] MIR_MATCH  = 16'h9800;

  typedef enum logic [1:0] {
    MIR_VERT  = 2'd0,
    MIR_HORZ  = 2'd1,
    MIR_ONE_A = 2'd2,
    MIR_ONE_B = 2'd3
  } mirror_e;

  typedef struct packed {
    logic lowb;
    logic b0;
    logic b1;
    logic b2;
    logic mir;
  } wr_sel_t;

  typedef struct packed {
    logic [LOWB_W-1:0] lowb;
    logic [DATA_W-1:0] b0;
    logic [DATA_W-1:0] b1;
    logic [DATA_W-1:0] b2;
    mirror_e           mir;
  } bank_state_t;
endpackage

// File: rtl/pbm_write_decode.sv
module pbm_write_decode
  import prg_bank_mapper_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output wr_sel_t           sel
);
  logic              in_win;
  logic              low_hit;
  logic [ADDR_W-1:0] masked;

  always_comb begin
    in_win  = addr[15] | (addr[14] & addr[13]);
    masked  = addr & REG_MASK;
    low_hit = ((addr & LOWW_MASK) == LOWW_MATCH);
    sel     = '0;
    if (we && in_win) begin
      if (low_hit) begin
        sel.lowb = 1'b1;
      end else begin
        unique case (masked)
          B0_MATCH:  sel.b0  = 1'b1;
          B1_MATCH:  sel.b1  = 1'b1;
          B2_MATCH:  sel.b2  = 1'b1;
          MIR_MATCH: sel.mir = 1'b1;
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pbm_bank_regs.sv
module pbm_bank_regs
  import prg_bank_mapper_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wr_sel_t           sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output bank_state_t       state
);
  bank_state_t state_q, state_d;
  logic        load_en;

  always_comb begin
    load_en = |sel;
    state_d = state_q;
    if (sel.lowb) state_d.lowb = addr[LOWB_W-1:0];
    if (sel.b0)   state_d.b0   = wdata;
    if (sel.b1)   state_d.b1   = wdata;
    if (sel.b2)   state_d.b2   = wdata;
    if (sel.mir)  state_d.mir  = mirror_e'(wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '{lowb: '0, b0: '0, b1: '0, b2: '0, mir: MIR_VERT};
    end else if (load_en) begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

  // R3
  lowb_from_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel.lowb |=> state_q.lowb == $past(addr[LOWB_W-1:0]));
  // R2
  b0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel.b0 |=> state_q.b0 == $past(wdata));
  // R4
  mir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel.mir |=> state_q.mir == mirror_e'($past(wdata[1:0])));
  // R8
  no_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|sel) |=> $stable(state_q));
  // R3
  lowb_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
endmodule

// File: rtl/pbm_read_map.sv
module pbm_read_map
  import prg_bank_mapper_pkg::*;
#(
  parameter int BANKS  = 32,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROM_AW = BANK_W + PAGE_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  bank_state_t       state,
  output logic [ROM_AW-1:0] rom_addr
);
  logic [DATA_W-1:0] sel_bank;
  logic [BANK_W-1:0] bank;
  logic              valid;
  logic              unused_sel;

  generate
    if (BANKS < 2 || BANKS > 256 || (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
      $error("BANKS must be a power of two from 2 to 256");
    end
  endgenerate

  always_comb begin
    valid    = 1'b1;
    sel_bank = '0;
    unique case (addr[15:13])
      3'd3:    sel_bank = {{(DATA_W-LOWB_W){1'b0}}, state.lowb};
      3'd4:    sel_bank = state.b0;
      3'd5:    sel_bank = state.b1;
      3'd6:    sel_bank = state.b2;
      3'd7:    sel_bank = DATA_W'(BANKS - 1);
      default: valid    = 1'b0;
    endcase
    bank     = sel_bank[BANK_W-1:0];
    rom_addr = valid ? {bank, addr[PAGE_W-1:0]} : '0;
  end

  assign unused_sel = ^sel_bank;

  always_comb begin
    // R6
    fixed_top_chk: assert (addr[15:13] != 3'd7 || rom_addr[ROM_AW-1:PAGE_W] == '1);
    // R9
    below_win_zero_chk: assert (addr[15] || (addr[14] && addr[13]) || rom_addr == '0);
  end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_bank_mapper_pkg::*;
#(
  parameter int BANKS  = 32,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROM_AW = BANK_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_we,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [1:0]        mirror_mode
);
  logic [1:0]  rst_sync_q;
  logic        rst_n_i;
  wr_sel_t     sel;
  bank_state_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  pbm_write_decode u_dec (
    .addr (cpu_addr),
    .we   (cpu_we),
    .sel  (sel)
  );

  pbm_bank_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n_i),
    .sel   (sel),
    .addr  (cpu_addr),
    .wdata (cpu_wdata),
    .state (state)
  );

  pbm_read_map #(.BANKS(BANKS)) u_map (
    .addr     (cpu_addr),
    .state    (state),
    .rom_addr (rom_addr)
  );

  assign mirror_mode = state.mir;
endmodule

// File: tb/prg_bank_mapper_bench.sv
`timescale 1ns/1ps
module prg_bank_mapper_bench;
  localparam int NB = 16;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [15:0]   cpu_addr;
  logic [7:0]    cpu_wdata;
  logic          cpu_we;
  logic [AW-1:0] rom_addr;
  logic [1:0]    mirror_mode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  int m_b0, m_b1, m_b2, m_lo, m_mir;

  always #2.5 clk = ~clk;

  prg_bank_mapper #(.BANKS(NB)) u_prg_bank_mapper (
    .clk, .rst_n, .cpu_addr, .cpu_wdata, .cpu_we, .rom_addr, .mirror_mode
  );

  function automatic int exp_rom(input logic [15:0] a);
    int bank;
    case (a[15:13])
      3'd3: bank = m_lo;
      3'd4: bank = m_b0;
      3'd5: bank = m_b1;
      3'd6: bank = m_b2;
      3'd7: bank = NB - 1;
      default: return 0;
    endcase
    return ((bank % NB) * 8192) + int'(a[12:0]);
  endfunction

  task automatic chk_rom(input logic [15:0] a, input string tag);
    @(negedge clk);
    cpu_addr = a;
    cpu_we   = 1'b0;
    #1;
    n_cmp++;
    if (int'(rom_addr) != exp_rom(a)) begin
      n_bad++;
      $display("FAIL %s addr=%h rom_addr=%h expected=%h", tag, a, rom_addr, exp_rom(a));
    end
  endtask

  task automatic chk_mir(input string tag);
    #1;
    n_cmp++;
    if (int'(mirror_mode) != m_mir) begin
      n_bad++;
      $display("FAIL %s mirror_mode=%0d expected=%0d", tag, mirror_mode, m_mir);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    logic [15:0] mk;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
    mk = a & 16'hF80C;
    if (a >= 16'h6000) begin
      if ((a & 16'hF800) == 16'h6800) m_lo = int'(a[5:0]);
      else if (mk == 16'h8800) m_b0 = int'(d);
      else if (mk == 16'hA800) m_b1 = int'(d);
      else if (mk == 16'hA000) m_b2 = int'(d);
      else if (mk == 16'h9800) m_mir = int'(d[1:0]);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int w = 3; w < 8; w++) begin
      chk_rom(16'(w * 16'h2000), tag);
      chk_rom(16'(w * 16'h2000 + 16'h1FFF), tag);
      chk_rom(16'(w * 16'h2000 + 16'h0A53), tag);
    end
    chk_mir(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_b0 = 0; m_b1 = 0; m_b2 = 0; m_lo = 0; m_mir = 0;
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_we = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state; R6 fixed top window
    chk_all("R1");
    chk_rom(16'hE123, "R6");

    // R2 R5 R7 bank register 0 sweep, alternating a mirror-image address
    for (int v = 0; v < 256; v++) begin
      wr((v % 2) ? 16'h8BF3 : 16'h8800, 8'(v));
      chk_rom(16'(16'h8000 + ((v * 37) % 8192)), "R2");
      chk_rom(16'h9FFF, "R7");
    end
    for (int v = 0; v < 256; v++) begin
      wr(16'hA800, 8'(v));
      chk_rom(16'(16'hA000 + ((v * 53) % 8192)), "R2");
    end
    for (int v = 0; v < 256; v++) begin
      wr(16'hA000, 8'(255 - v));
      chk_rom(16'(16'hC000 + ((v * 91) % 8192)), "R5");
    end
    wr(16'h8800, 8'h35);
    chk_rom(16'h8001, "R7");

    // R3 low window from address bits, data ignored, priority
    for (int a = 0; a < 64; a++) begin
      wr(16'(16'h6800 | a), 8'(~a));
      chk_rom(16'(16'h6000 + a * 100), "R3");
    end
    wr(16'h6FFF, 8'h00);
    chk_rom(16'h7ABC, "R3");
    chk_all("R3");

    // R4 mirroring via mirror-image address
    for (int m = 0; m < 8; m++) begin
      wr(16'h9BF3, 8'({5'h15, 3'(m)}));
      chk_mir("R4");
    end
    wr(16'h9800, 8'h02);
    chk_mir("R4");

    // R8 unmatched writes and writes with strobe low
    wr(16'h8804, 8'h0B); wr(16'h9000, 8'h0C); wr(16'hB000, 8'h0D);
    wr(16'hC000, 8'h0E); wr(16'hF000, 8'h01); wr(16'h6000, 8'h03);
    wr(16'h7000, 8'h07); wr(16'hF00C, 8'h09); wr(16'hE00C, 8'h03);
    chk_all("R8");
    @(negedge clk);
    cpu_addr = 16'h8800; cpu_wdata = 8'h09; cpu_we = 1'b0;
    @(negedge clk);
    cpu_addr = 16'h9800; cpu_wdata = 8'h01;
    @(negedge clk);
    chk_all("R8");

    // R9 below the decoded range
    wr(16'h0800, 8'h07); wr(16'h5800, 8'h07); wr(16'h2800, 8'h01);
    chk_rom(16'h0000, "R9");
    chk_rom(16'h5FFF, "R9");
    chk_rom(16'h4321, "R9");
    chk_all("R9");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule